// File: doc/BRIEF.md
# Burst-Four Double-Data-Rate Static Memory with Write Forwarding

This block is a synchronous static memory with a double-data-rate data port. Every access moves a burst of four data words, two per clock cycle: one word on a rise lane and one on a fall lane, standing for the two edges of the clock. A host starts an operation by pulling an active-low load strobe low in a cycle where the block is ready for a command. A read/write select and a burst base address are sampled together with the strobe. A burst always covers four consecutive words. Their two low word-address bits run 00, 01, 10, 11 from the base.

Write data does not go straight into the array. It collects in a four-word holding register and is committed only when the next write begins to arrive, so a write followed at once by a read of the same burst can be served at full speed. Such a read takes each of its beats from the holding register and not from the array. The host sees the same timing and protocol as for any other read. Read data comes out through a retiming stage whose reference is chosen by a pair of output-clock pins. When both pins are tied high, the input clock is the reference. Otherwise the data is relaunched on the output clock, which the model represents as one extra cycle of latency. A pair of echo flags marks the cycles that carry read data.

The command slot is governed by a five-state machine. ST_IDLE is the ready state with no burst under way. ST_WR_LO and ST_WR_HI are the two data cycles of a write. ST_RD_LO and ST_RD_HI are the two fetch cycles of a read. Commands are taken in ST_IDLE, ST_WR_HI and ST_RD_HI. A read command moves the machine to ST_RD_LO and a write command moves it to ST_WR_LO. With no command, the machine goes to ST_IDLE. ST_WR_LO always moves to ST_WR_HI, and ST_RD_LO always moves to ST_RD_HI.

Top module: `qb_ddr_sram`

## Requirements
- R1: Every command transfers exactly four beats over two consecutive cycles. The rise lane carries beat 0 and then beat 2, the fall lane carries beat 1 and then beat 3, and `rd_valid_o` is high in exactly those two cycles of a read.
- R2: At a clock edge where a command is accepted, `load_ni` low starts an operation. `rd_wr_i` high selects a read and low selects a write. `base_addr_i` names the four words {base, 00} to {base, 11}, and this includes the lowest base and the highest base.
- R3: In the cycle right after an accepted command, `load_ni` is ignored. A read presented there produces no output beats.
- R4: Write beats 0 and 1 are sampled on `wd_rise_i`/`wd_fall_i` at the first edge after the command edge, and beats 2 and 3 at the second edge. The next command may be presented at that second edge.
- R5: With `oclk_p_i` and `oclk_n_i` both high, read beats 0/1 are on the outputs after the second edge that follows the command edge, and beats 2/3 after the third.
- R6: With the output-clock pins not both high, every read result is due one cycle later than in R5.
- R7: A read issued in the slot right after a write to the same base returns the newly written data, beat by beat.
- R8: Held write data is committed to the array when the next write's first beats are captured. Data of an earlier write stays readable after later writes to other bases, and a rewrite of a base returns its latest data.
- R9: In every cycle without a read beat, `rd_valid_o` is low and both read lanes are zero.
- R10: `echo_p_o` and `echo_n_o` are high in exactly the cycles in which `rd_valid_o` is high.
- R11: While reset is held and just after it is released, no read beat is shown and both lanes are zero. A command is accepted at the first edge after release.
- R12: Idle cycles leave the holding register unchanged, so a read after any number of idle cycles still returns the held write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_ni | input | 1 | Active-low command strobe |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| base_addr_i | input | BASE_W | Burst base address |
| wd_rise_i | input | DATA_W | Write beat on the rising-edge lane |
| wd_fall_i | input | DATA_W | Write beat on the falling-edge lane |
| oclk_p_i | input | 1 | Output clock, true pin |
| oclk_n_i | input | 1 | Output clock, complement pin |
| rd_rise_o | output | DATA_W | Read beat on the rising-edge lane |
| rd_fall_o | output | DATA_W | Read beat on the falling-edge lane |
| rd_valid_o | output | 1 | Read lanes carry a beat |
| echo_p_o | output | 1 | Echo flag, true |
| echo_n_o | output | 1 | Echo flag, complement lane |

## Verification
Take the edge at which a read command is sampled as E. In input-clock mode, beats 0/1 are due after edge E+2 and beats 2/3 after edge E+3. In output-clock mode, both are due one edge later. Write beats are driven so that they are sampled at edges E+1 and E+2. The bench keeps a behavioural word memory that is updated when a write is issued, and writes the expected lane values for each future cycle into a table indexed by cycle. Every clock, away from the edge, it compares the lanes, the valid flag and the echo flags with that table, so that a beat arriving a cycle early or late shows up as a mismatch. The output-clock mode changes only after enough idle cycles that no result from the previous mode is still due.

// File: rtl/qb_ddr_pkg.sv
package qb_ddr_pkg;

    // command slot states; commands are taken in IDLE, WR_HI and RD_HI
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR_LO = 3'd1,
        ST_WR_HI = 3'd2,
        ST_RD_LO = 3'd3,
        ST_RD_HI = 3'd4
    } slot_state_e;

    localparam int BURST_LEN = 4;
    localparam int LANES     = 2;

endpackage

// File: rtl/qb_ddr_slot_ctrl.sv
module qb_ddr_slot_ctrl
    import qb_ddr_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_ni,
    input  logic              rd_wr_i,
    input  logic [BASE_W-1:0] base_addr_i,
    output slot_state_e       state_o,
    output logic [BASE_W-1:0] cmd_base_o
);

    slot_state_e cur_q;
    slot_state_e nxt;
    logic        slot_open;
    logic        take;

    always_comb begin
        slot_open = (cur_q == ST_IDLE) || (cur_q == ST_WR_HI) || (cur_q == ST_RD_HI);
        take      = slot_open && !load_ni;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_IDLE, ST_WR_HI, ST_RD_HI: begin
                if (take) begin
                    nxt = rd_wr_i ? ST_RD_LO : ST_WR_LO;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_WR_LO: nxt = ST_WR_HI;
            ST_RD_LO: nxt = ST_RD_HI;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= ST_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    // command outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmd_base_o <= '0;
        end else if (take) begin
            cmd_base_o <= base_addr_i;
        end
    end

    assign state_o = cur_q;

endmodule

// File: rtl/qb_ddr_store.sv
module qb_ddr_store
    import qb_ddr_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int BASE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  slot_state_e       state_i,
    input  logic [BASE_W-1:0] cmd_base_i,
    input  logic [DATA_W-1:0] wd_rise_i,
    input  logic [DATA_W-1:0] wd_fall_i,
    output logic [DATA_W-1:0] stg_rise_o,
    output logic [DATA_W-1:0] stg_fall_o,
    output logic              stg_vld_o,
    output logic              hold_vld_o
);

    localparam int WORD_W = BASE_W + 2;
    localparam int DEPTH  = 1 << WORD_W;

    logic [DATA_W-1:0] mem_q  [DEPTH];
    logic [DATA_W-1:0] hold_q [BURST_LEN];
    logic [BASE_W-1:0] hold_base_q;
    logic              hold_vld_q;
    logic [DATA_W-1:0] pick   [LANES];
    logic [DATA_W-1:0] stg_q  [LANES];
    logic              stg_vld_q;
    logic              fwd_hit;
    logic              upper_half;
    logic              rd_phase;

    always_comb begin
        fwd_hit    = hold_vld_q && (hold_base_q == cmd_base_i);
        upper_half = (state_i == ST_RD_HI);
        rd_phase   = (state_i == ST_RD_LO) || (state_i == ST_RD_HI);
    end

    // commit the previous burst as the next write's first beats land
    always_ff @(posedge clk_i) begin
        if (state_i == ST_WR_LO && hold_vld_q) begin
            for (int b = 0; b < BURST_LEN; b++) begin
                mem_q[{hold_base_q, 2'(b)}] <= hold_q[b];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (state_i == ST_WR_LO) begin
            hold_q[0] <= wd_rise_i;
            hold_q[1] <= wd_fall_i;
        end else if (state_i == ST_WR_HI) begin
            hold_q[2] <= wd_rise_i;
            hold_q[3] <= wd_fall_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_base_q <= '0;
            hold_vld_q  <= 1'b0;
        end else if (state_i == ST_WR_LO) begin
            hold_base_q <= cmd_base_i;
            hold_vld_q  <= 1'b1;
        end
    end

    // per-lane source choice: holding register on a base match, array otherwise
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0]        beat;
        logic [WORD_W-1:0] waddr;
        assign beat    = {upper_half, 1'(g)};
        assign waddr   = {cmd_base_i, beat};
        assign pick[g] = fwd_hit ? hold_q[beat] : mem_q[waddr];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stg_vld_q <= 1'b0;
            for (int l = 0; l < LANES; l++) stg_q[l] <= '0;
        end else if (rd_phase) begin
            stg_vld_q <= 1'b1;
            for (int l = 0; l < LANES; l++) stg_q[l] <= pick[l];
        end else begin
            stg_vld_q <= 1'b0;
            for (int l = 0; l < LANES; l++) stg_q[l] <= '0;
        end
    end

    assign stg_rise_o = stg_q[0];
    assign stg_fall_o = stg_q[1];
    assign stg_vld_o  = stg_vld_q;
    assign hold_vld_o = hold_vld_q;

endmodule

// File: rtl/qb_ddr_out_retime.sv
module qb_ddr_out_retime #(
    parameter int DATA_W     = 36,
    parameter int OCLK_EXTRA = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] stg_rise_i,
    input  logic [DATA_W-1:0] stg_fall_i,
    input  logic              stg_vld_i,
    input  logic              oclk_p_i,
    input  logic              oclk_n_i,
    output logic [DATA_W-1:0] rd_rise_o,
    output logic [DATA_W-1:0] rd_fall_o,
    output logic              rd_valid_o,
    output logic              echo_p_o,
    output logic              echo_n_o
);

    localparam int PW    = 2 * DATA_W + 1;
    localparam int NSTG  = OCLK_EXTRA + 1;

    logic [PW-1:0] pipe_q [NSTG];
    logic [PW-1:0] sel;
    logic          in_clk_ref;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < NSTG; s++) pipe_q[s] <= '0;
        end else begin
            pipe_q[0] <= {stg_vld_i, stg_rise_i, stg_fall_i};
            for (int s = 1; s < NSTG; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    // both output-clock pins high: the input clock launches the data
    always_comb begin
        in_clk_ref = oclk_p_i & oclk_n_i;
        sel        = in_clk_ref ? pipe_q[0] : pipe_q[NSTG-1];
    end

    assign rd_valid_o = sel[PW-1];
    assign rd_rise_o  = sel[2*DATA_W-1 -: DATA_W];
    assign rd_fall_o  = sel[DATA_W-1:0];
    assign echo_p_o   = sel[PW-1];
    assign echo_n_o   = sel[PW-1];

endmodule

// File: rtl/qb_ddr_sram.sv
module qb_ddr_sram
    import qb_ddr_pkg::*;
#(
    parameter int DATA_W     = 36,
    parameter int BASE_W     = 8,
    parameter int OCLK_EXTRA = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_ni,
    input  logic              rd_wr_i,
    input  logic [BASE_W-1:0] base_addr_i,
    input  logic [DATA_W-1:0] wd_rise_i,
    input  logic [DATA_W-1:0] wd_fall_i,
    input  logic              oclk_p_i,
    input  logic              oclk_n_i,
    output logic [DATA_W-1:0] rd_rise_o,
    output logic [DATA_W-1:0] rd_fall_o,
    output logic              rd_valid_o,
    output logic              echo_p_o,
    output logic              echo_n_o
);

    slot_state_e       cur_state;
    logic [BASE_W-1:0] cmd_base;
    logic [DATA_W-1:0] stg_rise;
    logic [DATA_W-1:0] stg_fall;
    logic              stg_vld;
    logic              hold_valid;

    qb_ddr_slot_ctrl #(.BASE_W(BASE_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_ni    (load_ni),
        .rd_wr_i    (rd_wr_i),
        .base_addr_i(base_addr_i),
        .state_o    (cur_state),
        .cmd_base_o (cmd_base)
    );

    qb_ddr_store #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .state_i   (cur_state),
        .cmd_base_i(cmd_base),
        .wd_rise_i (wd_rise_i),
        .wd_fall_i (wd_fall_i),
        .stg_rise_o(stg_rise),
        .stg_fall_o(stg_fall),
        .stg_vld_o (stg_vld),
        .hold_vld_o(hold_valid)
    );

    qb_ddr_out_retime #(.DATA_W(DATA_W), .OCLK_EXTRA(OCLK_EXTRA)) u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stg_rise_i(stg_rise),
        .stg_fall_i(stg_fall),
        .stg_vld_i (stg_vld),
        .oclk_p_i  (oclk_p_i),
        .oclk_n_i  (oclk_n_i),
        .rd_rise_o (rd_rise_o),
        .rd_fall_o (rd_fall_o),
        .rd_valid_o(rd_valid_o),
        .echo_p_o  (echo_p_o),
        .echo_n_o  (echo_n_o)
    );

endmodule

// File: rtl/qb_ddr_sram_chk.sv
module qb_ddr_sram_chk
    import qb_ddr_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk_i,
    input logic              rst_ni,
    input slot_state_e       state,
    input logic              hold_valid,
    input logic              oclk_p_i,
    input logic              oclk_n_i,
    input logic [DATA_W-1:0] rd_rise_o,
    input logic [DATA_W-1:0] rd_fall_o,
    input logic              rd_valid_o,
    input logic              echo_p_o,
    input logic              echo_n_o
);

    // R3: the cycle after a write command cannot take a new command
    assert_wr_slot_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_WR_LO) |=> (state == ST_WR_HI));

    // R3: the same for a read command
    assert_rd_slot_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RD_LO) |=> (state == ST_RD_HI));

    // R5: input-clock reference, first beats two edges after the fetch starts
    assert_in_clk_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RD_LO && oclk_p_i && oclk_n_i) |-> ##2 rd_valid_o);

    // R6: output-clock reference adds one cycle
    assert_out_clk_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RD_LO && !(oclk_p_i && oclk_n_i)) |-> ##3 rd_valid_o);

    // R1: a burst never shows fewer than two beat cycles
    assert_burst_two_cycles_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_valid_o) |=> rd_valid_o);

    // R9: idle lanes read as zero
    assert_idle_lanes_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_o |-> (rd_rise_o == '0 && rd_fall_o == '0));

    // R10: echo flags follow the data valid
    assert_echo_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (echo_p_o == rd_valid_o) && (echo_n_o == rd_valid_o));

    // R12: once data is held it is never dropped
    assert_hold_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_valid |=> hold_valid);

endmodule

bind qb_ddr_sram qb_ddr_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state     (cur_state),
    .hold_valid(hold_valid),
    .oclk_p_i  (oclk_p_i),
    .oclk_n_i  (oclk_n_i),
    .rd_rise_o (rd_rise_o),
    .rd_fall_o (rd_fall_o),
    .rd_valid_o(rd_valid_o),
    .echo_p_o  (echo_p_o),
    .echo_n_o  (echo_n_o)
);

// File: tb/qb_ddr_sram_tb.sv
module qb_ddr_sram_tb;

    localparam int DW     = 36;
    localparam int BW     = 8;
    localparam int NEXP   = 2048;
    localparam int NWORDS = 4 << BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          rw = 1'b0;
    logic [BW-1:0] addr = '0;
    logic [DW-1:0] wd_r = '0;
    logic [DW-1:0] wd_f = '0;
    logic          oclk_p = 1'b1;
    logic          oclk_n = 1'b1;
    logic [DW-1:0] rd_r;
    logic [DW-1:0] rd_f;
    logic          rd_v;
    logic          ep;
    logic          en;

    int            cyc = 0;
    int            checks = 0;
    int            failures = 0;
    bit            run_chk = 1'b0;
    bit            done = 1'b0;
    bit            mode_in = 1'b1;
    logic [DW-1:0] pend_r = '0;
    logic [DW-1:0] pend_f = '0;

    logic [DW-1:0] refm [NWORDS];
    bit            ev [NEXP];
    logic [DW-1:0] er [NEXP];
    logic [DW-1:0] ef [NEXP];
    string         et [NEXP];

    always #5 clk = ~clk;

    qb_ddr_sram #(.DATA_W(DW), .BASE_W(BW), .OCLK_EXTRA(1)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_ni    (load_n),
        .rd_wr_i    (rw),
        .base_addr_i(addr),
        .wd_rise_i  (wd_r),
        .wd_fall_i  (wd_f),
        .oclk_p_i   (oclk_p),
        .oclk_n_i   (oclk_n),
        .rd_rise_o  (rd_r),
        .rd_fall_o  (rd_f),
        .rd_valid_o (rd_v),
        .echo_p_o   (ep),
        .echo_n_o   (en)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(input int base, input int seed, input int b);
        return {4'(b + seed), 16'(base * 37 + seed), 16'(seed * 911 + b * 53 + base)};
    endfunction

    // per-cycle comparison against the expectation table
    always @(negedge clk) begin
        if (run_chk && cyc > 0 && cyc < NEXP) begin
            checks++;
            if (rd_v !== ev[cyc] || rd_r !== er[cyc] || rd_f !== ef[cyc])
                begin
                failures++;
                $display("FAIL %s cycle %0d: got v=%b r=%h f=%h exp v=%b r=%h f=%h",
                         et[cyc], cyc, rd_v, rd_r, rd_f, ev[cyc], er[cyc], ef[cyc]);
            end
            checks++;
            if (ep !== ev[cyc] || en !== ev[cyc]) begin
                failures++;
                $display("FAIL R10 cycle %0d: echo p=%b n=%b exp %b", cyc, ep, en, ev[cyc]);
            end
        end
    end

    // op: 0 idle, 1 write, 2 read; ign places an ignored read in the busy cycle
    task automatic slot(input int op, input int base, input int seed,
                        input string tag, input bit ign);
        int e;
        int lat;
        logic [DW-1:0] d [4];
        @(negedge clk);
        e      = cyc + 1;
        lat    = mode_in ? 2 : 3;
        load_n = (op == 0);
        rw     = (op == 2);
        addr   = BW'(base);
        wd_r   = pend_r;
        wd_f   = pend_f;
        for (int k = 0; k < 4; k++) d[k] = pat(base, seed, k);
        if (op == 1) begin
            for (int k = 0; k < 4; k++) refm[base * 4 + k] = d[k];
        end
        if (op == 2) begin
            ev[e+lat]   = 1'b1;
            er[e+lat]   = refm[base * 4 + 0];
            ef[e+lat]   = refm[base * 4 + 1];
            et[e+lat]   = tag;
            ev[e+lat+1] = 1'b1;
            er[e+lat+1] = refm[base * 4 + 2];
            ef[e+lat+1] = refm[base * 4 + 3];
            et[e+lat+1] = tag;
            if (ign) et[e+lat+2] = "R3";
        end
        @(negedge clk);
        load_n = ign ? 1'b0 : 1'b1;
        rw     = 1'b1;
        addr   = ign ? BW'(base ^ 1) : addr;
        if (op == 1) begin
            wd_r   = d[0];
            wd_f   = d[1];
            pend_r = d[2];
            pend_f = d[3];
        end else begin
            wd_r   = '0;
            wd_f   = '0;
            pend_r = '0;
            pend_f = '0;
        end
    endtask

    initial begin
        for (int i = 0; i < NEXP; i++) begin
            ev[i] = 1'b0;
            er[i] = '0;
            ef[i] = '0;
            et[i] = "R9";
        end
        repeat (3) @(negedge clk);
        // R11: reset holds the outputs idle
        checks++;
        if (rd_v !== 1'b0 || rd_r !== '0 || rd_f !== '0 || ep !== 1'b0) begin
            failures++;
            $display("FAIL R11 in reset: v=%b r=%h f=%h exp 0", rd_v, rd_r, rd_f);
        end
        rst_n   = 1'b1;
        run_chk = 1'b1;
        checks++;
        if (rd_v !== 1'b0 || rd_r !== '0 || rd_f !== '0) begin
            failures++;
            $display("FAIL R11 after release: v=%b r=%h f=%h exp 0", rd_v, rd_r, rd_f);
        end

        // R11: command taken at the first edge after release; R7 forwarding
        slot(1, 3, 1, "R11", 0);
        slot(2, 3, 0, "R7", 0);
        // R8: commit on the next write, array read of the older burst
        slot(1, 5, 2, "R8", 0);
        slot(1, 9, 3, "R8", 0);
        slot(2, 5, 0, "R8", 0);
        slot(2, 9, 0, "R7", 0);
        slot(2, 3, 0, "R8", 0);
        // R12: rewrite, idle gap, then read of the held burst
        slot(1, 3, 4, "R12", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);
        slot(2, 3, 0, "R12", 0);
        // R3: a read in the busy cycle is ignored
        slot(2, 5, 0, "R3", 1);
        slot(0, 0, 0, "R9", 0);
        // R1/R5: back-to-back reads
        slot(2, 9, 0, "R5", 0);
        slot(2, 3, 0, "R1", 0);
        // R2/R4: lowest and highest bases, back-to-back writes
        slot(1, 0, 5, "R4", 0);
        slot(1, (1 << BW) - 1, 6, "R2", 0);
        slot(2, 0, 0, "R2", 0);
        slot(2, (1 << BW) - 1, 0, "R2", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);

        // R6: output clock supplied
        @(negedge clk);
        mode_in = 1'b0;
        oclk_p  = 1'b0;
        oclk_n  = 1'b1;
        slot(0, 0, 0, "R9", 0);
        slot(2, 5, 0, "R6", 0);
        slot(1, 3, 7, "R6", 0);
        slot(2, 3, 0, "R6", 0);
        slot(2, 9, 0, "R6", 0);
        slot(2, (1 << BW) - 1, 0, "R6", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);

        // back to the input clock reference
        @(negedge clk);
        mode_in = 1'b1;
        oclk_p  = 1'b1;
        oclk_n  = 1'b1;
        slot(0, 0, 0, "R9", 0);
        slot(2, 3, 0, "R5", 0);
        slot(1, 9, 8, "R7", 0);
        slot(2, 9, 0, "R7", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);
        slot(0, 0, 0, "R9", 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule